// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This unit sits between a 32-bit integer pipeline and a word-wide data memory port. It takes the instruction word of a load or store, the base register value and, for stores, the source register value. It rebuilds the 12-bit offset from the instruction fields and adds it, sign-extended, to the base. The result is the effective address. The memory port receives the word-aligned address, a byte-enable strobe per lane and the store data copied onto every lane, so that the lanes the strobe selects carry the right bytes.

For loads, the unit records the access size, the extension mode and the byte offset when memory accepts the request. One cycle later it takes the returned word, picks the addressed byte or halfword and extends it to 32 bits. A halfword or word access that does not fall on its natural boundary is flagged and never reaches memory. While a load is waiting for its data the unit reports busy and holds off any new request.

The access kind comes from instruction bits 14:12. Bits 13:12 give the size (00 byte, 01 halfword, 10 word, 11 handled as word). Bit 14 set selects zero extension.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is base plus the 12-bit offset sign-extended to the address width, and mem_addr carries that address with its two low bits cleared.
- R2: For loads the offset is instruction bits 31:20. For stores it is bits 31:25 above bits 11:7.
- R3: A byte access drives mem_be = 0001 shifted left by the address bits 1:0, and a byte store places source bits 7:0 on all four lanes of mem_wdata.
- R4: A halfword access drives mem_be = 0011 shifted left by the address bits 1:0, and a halfword store places source bits 15:0 in both halves of mem_wdata.
- R5: A word access drives mem_be = 1111, and a word store passes all 32 source bits to mem_wdata.
- R6: A load with instruction bit 14 clear fills bits 31:8 (byte) or 31:16 (halfword) of ld_data with the sign bit of the selected data.
- R7: A load with instruction bit 14 set fills those upper bits with zeros. A word load returns the whole memory word.
- R8: A halfword access with address bit 0 set, or a word access with address bits 1:0 not 00, raises misalign and keeps mem_req low.
- R9: ld_valid and busy are high in the cycle after memory accepts a load (mem_req and mem_ready both high). In that cycle ld_data is formed from mem_rdata, and mem_req stays low while busy is high.
- R10: mem_we follows req_store. An accepted store does not raise busy or ld_valid.
- R11: After reset, busy and ld_valid are low.
- R12: A request held while mem_ready is low is not taken: req_taken is low and no load response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core presents a load or store |
| req_store | input | 1 | 1 = store, 0 = load |
| insn | input | 32 | Instruction word (offset fields and access kind) |
| base | input | ADDR_W | Base register value |
| src_data | input | 32 | Store source register value |
| req_taken | output | 1 | Request accepted by memory this cycle |
| misalign | output | 1 | Presented request is not naturally aligned |
| mem_req | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | DATA_W/8 | Byte-lane enables |
| mem_wdata | output | DATA_W | Lane-steered store data |
| mem_rdata | input | DATA_W | Load data, valid the cycle after acceptance |
| ld_valid | output | 1 | ld_data is valid |
| ld_data | output | 32 | Extended load result |
| busy | output | 1 | A load is waiting for its data |

## Verification
The bench builds the unit with its defaults: a 32-bit address and a 32-bit data port, giving four lanes. With these values every byte offset and every size and extension pairing can be reached. The vectors include offsets that wrap the base downward through the most negative immediate, store offsets split across both instruction fields, and sign bits placed in each lane. Directed cases cover the busy window with a request still held, and memory stalling with mem_ready low.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WIDE = 2'b11
   } acc_size_e;

   typedef struct packed {
      acc_size_e size;
      logic      zext;
   } acc_kind_t;

   function automatic acc_kind_t decode_kind(input logic [2:0] f3);
      acc_kind_t k;
      k.zext = f3[2];
      k.size = (f3[1:0] == 2'b11) ? SZ_WORD : acc_size_e'(f3[1:0]);
      return k;
   endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
   parameter int ADDR_W = 32
) (
   input  logic [31:0]       insn,
   input  logic              is_store,
   input  logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] ea
);
   localparam int IMM_W = 12;

   logic [IMM_W-1:0]  imm;
   logic [ADDR_W-1:0] imm_sx;
   logic              unused_fields;

   generate
      if (ADDR_W <= IMM_W) begin : g_bad_width
         $error("lsu_agen: ADDR_W must exceed the offset width");
      end
   endgenerate

   assign imm    = is_store ? {insn[31:25], insn[11:7]} : insn[31:20];
   assign imm_sx = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
   assign ea     = base + imm_sx;

   assign unused_fields = ^{insn[19:12], insn[6:0]};
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  acc_size_e           size,
   input  logic [$clog2(DATA_W/8)-1:0] off,
   input  logic [31:0]         src,
   output logic [DATA_W/8-1:0] be,
   output logic [DATA_W-1:0]   wdata,
   output logic                bad_align
);
   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] rep_b, rep_h, rep_w;

   generate
      if (DATA_W % 32 != 0) begin : g_bad_width
         $error("lsu_store_steer: DATA_W must be a multiple of 32");
      end
      for (genvar g = 0; g < LANES; g++) begin : g_rep_b
         assign rep_b[g*8 +: 8] = src[7:0];
      end
      for (genvar g = 0; g < LANES/2; g++) begin : g_rep_h
         assign rep_h[g*16 +: 16] = src[15:0];
      end
      for (genvar g = 0; g < LANES/4; g++) begin : g_rep_w
         assign rep_w[g*32 +: 32] = src;
      end
   endgenerate

   always_comb begin
      unique case (size)
         SZ_BYTE: begin
            be        = LANES'(1) << off;
            wdata     = rep_b;
            bad_align = 1'b0;
         end
         SZ_HALF: begin
            be        = LANES'(3) << off;
            wdata     = rep_h;
            bad_align = off[0];
         end
         default: begin
            be        = LANES'(15) << off;
            wdata     = rep_w;
            bad_align = |off[1:0];
         end
      endcase
   end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0]           rdata,
   input  logic [$clog2(DATA_W/8)-1:0] off,
   input  acc_size_e                   size,
   input  logic                        zext,
   output logic [31:0]                 result
);
   localparam int OFF_W = $clog2(DATA_W/8);

   logic [DATA_W-1:0] sh;
   logic [7:0]        b;
   logic [15:0]       h;

   assign sh = rdata >> {off, 3'b000};
   assign b  = sh[7:0];
   assign h  = sh[15:0];

   generate
      if (OFF_W < 2) begin : g_bad_lanes
         $error("lsu_load_extract: at least four lanes are needed");
      end
   endgenerate

   always_comb begin
      unique case (size)
         SZ_BYTE: result = zext ? {24'h0, b} : {{24{b[7]}}, b};
         SZ_HALF: result = zext ? {16'h0, h} : {{16{h[15]}}, h};
         default: result = sh[31:0];
      endcase
   end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
   import lsu_align_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_store,
   input  logic [31:0]         insn,
   input  logic [ADDR_W-1:0]   base,
   input  logic [31:0]         src_data,
   output logic                req_taken,
   output logic                misalign,
   output logic                mem_req,
   input  logic                mem_ready,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0]   mem_wdata,
   input  logic [DATA_W-1:0]   mem_rdata,
   output logic                ld_valid,
   output logic [31:0]         ld_data,
   output logic                busy
);
   localparam int LANES = DATA_W / 8;
   localparam int OFF_W = $clog2(LANES);

   acc_kind_t        kind, kind_q;
   logic [ADDR_W-1:0] ea;
   logic [OFF_W-1:0]  off, off_q;
   logic              bad_align;
   logic              pend_q;

   assign kind = decode_kind(insn[14:12]);

   lsu_agen #(.ADDR_W(ADDR_W)) u_agen (
      .insn     (insn),
      .is_store (req_store),
      .base     (base),
      .ea       (ea)
   );

   assign off = ea[OFF_W-1:0];

   lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
      .size      (kind.size),
      .off       (off),
      .src       (src_data),
      .be        (mem_be),
      .wdata     (mem_wdata),
      .bad_align (bad_align)
   );

   assign misalign  = req_valid & bad_align;
   assign mem_req   = req_valid & ~bad_align & ~pend_q;
   assign req_taken = mem_req & mem_ready;
   assign mem_we    = req_store;
   assign mem_addr  = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         kind_q <= '{size: SZ_BYTE, zext: 1'b0};
         off_q  <= '0;
      end else begin
         pend_q <= req_taken & ~req_store;
         if (req_taken && !req_store) begin
            kind_q <= kind;
            off_q  <= off;
         end
      end
   end

   lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
      .rdata  (mem_rdata),
      .off    (off_q),
      .size   (kind_q.size),
      .zext   (kind_q.zext),
      .result (ld_data)
   );

   assign ld_valid = pend_q;
   assign busy     = pend_q;

   AST_MISALIGN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> !mem_req); // R8
   AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !mem_req); // R9
   AST_LOAD_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_taken && !req_store) |=> ld_valid); // R9
   AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> $past(req_taken && !req_store)); // R9
   AST_STORE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_taken && req_store) |=> !busy); // R10
   AST_STALL_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> !ld_valid); // R12
   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && kind.size == SZ_BYTE) |-> $countones(mem_be) == 1); // R3
   AST_WORD_FOUR_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && kind.size == SZ_WORD) |-> $countones(mem_be) == 4); // R5
endmodule

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_store = 1'b0, mem_ready = 1'b0;
   logic [31:0] insn = '0, base = '0, src_data = '0, mem_rdata = '0;
   logic        req_taken, misalign, mem_req, mem_we, ld_valid, busy;
   logic [31:0] mem_addr, mem_wdata, ld_data;
   logic [3:0]  mem_be;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   lsu_lane_align u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .insn(insn), .base(base), .src_data(src_data), .req_taken(req_taken),
      .misalign(misalign), .mem_req(mem_req), .mem_ready(mem_ready),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
      .ld_data(ld_data), .busy(busy)
   );

   typedef struct packed {
      logic        st;
      logic [2:0]  f3;
      logic [31:0] base;
      logic [11:0] imm;
      logic [31:0] wd;
      logic [31:0] rd;
      logic [31:0] e_addr;
      logic [3:0]  e_be;
      logic        e_mis;
      logic [31:0] e_out;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      // R3 byte store, offset 3
      '{1'b1, 3'b000, 32'h0000_1000, 12'h003, 32'h1234_56AB, 32'h0, 32'h0000_1000, 4'b1000, 1'b0, 32'hABAB_ABAB},
      // R4 halfword store, negative offset, R2 split immediate
      '{1'b1, 3'b001, 32'h2000_0010, 12'hFFE, 32'hDEAD_BEEF, 32'h0, 32'h2000_000C, 4'b1100, 1'b0, 32'hBEEF_BEEF},
      // R5 word store, largest positive offset
      '{1'b1, 3'b010, 32'h0000_0100, 12'h7FC, 32'hCAFE_F00D, 32'h0, 32'h0000_08FC, 4'b1111, 1'b0, 32'hCAFE_F00D},
      // R6 signed byte load, lane 1
      '{1'b0, 3'b000, 32'h0000_3000, 12'h001, 32'h0, 32'h1122_8344, 32'h0000_3000, 4'b0010, 1'b0, 32'hFFFF_FF83},
      // R7 unsigned byte load, lane 1
      '{1'b0, 3'b100, 32'h0000_3000, 12'h001, 32'h0, 32'h1122_8344, 32'h0000_3000, 4'b0010, 1'b0, 32'h0000_0083},
      // R6 signed halfword load, upper half
      '{1'b0, 3'b001, 32'h0000_4000, 12'h002, 32'h0, 32'h9ABC_1234, 32'h0000_4000, 4'b1100, 1'b0, 32'hFFFF_9ABC},
      // R7 unsigned halfword load, upper half
      '{1'b0, 3'b101, 32'h0000_4000, 12'h002, 32'h0, 32'h9ABC_1234, 32'h0000_4000, 4'b1100, 1'b0, 32'h0000_9ABC},
      // R1 word load, most negative offset
      '{1'b0, 3'b010, 32'h0000_5008, 12'h800, 32'h0, 32'h7654_3210, 32'h0000_4808, 4'b1111, 1'b0, 32'h7654_3210},
      // R8 halfword store on odd address
      '{1'b1, 3'b001, 32'h0000_6000, 12'h001, 32'h0, 32'h0, 32'h0000_6000, 4'b0000, 1'b1, 32'h0},
      // R8 word load on offset 2
      '{1'b0, 3'b010, 32'h0000_6000, 12'h002, 32'h0, 32'h0, 32'h0000_6000, 4'b0000, 1'b1, 32'h0},
      // R6 signed byte load with clear sign bit, lane 0
      '{1'b0, 3'b000, 32'h0000_7000, 12'h000, 32'h0, 32'hFFFF_FF7F, 32'h0000_7000, 4'b0001, 1'b0, 32'h0000_007F},
      // R4 halfword store, offset 0
      '{1'b1, 3'b001, 32'h0000_8000, 12'h000, 32'h1234_5678, 32'h0, 32'h0000_8000, 4'b0011, 1'b0, 32'h5678_5678}
   };

   function automatic logic [31:0] mk_insn(input logic st, input logic [2:0] f3,
                                           input logic [11:0] imm);
      if (st) return {imm[11:5], 5'd9, 5'd10, f3, imm[4:0], 7'b0100011};
      else    return {imm, 5'd10, f3, 5'd11, 7'b0000011};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R11 reset state
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R11 busy in reset", 32'(busy), 32'h0);
      chk(ld_valid == 1'b0, "R11 ld_valid in reset", 32'(ld_valid), 32'h0);
      rst_n = 1'b1;
      mem_ready = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R11 busy after reset", 32'(busy), 32'h0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         req_valid = 1'b1;
         req_store = VEC[i].st;
         insn      = mk_insn(VEC[i].st, VEC[i].f3, VEC[i].imm);
         base      = VEC[i].base;
         src_data  = VEC[i].wd;
         mem_rdata = VEC[i].rd;
         #2;
         chk(mem_addr == VEC[i].e_addr, "R1 R2 address", mem_addr, VEC[i].e_addr);
         chk(misalign == VEC[i].e_mis, "R8 misalign", 32'(misalign), 32'(VEC[i].e_mis));
         chk(mem_req == !VEC[i].e_mis, "R8 mem_req", 32'(mem_req), 32'(!VEC[i].e_mis));
         if (!VEC[i].e_mis) begin
            chk(mem_be == VEC[i].e_be, "R3 R4 R5 byte enables", 32'(mem_be), 32'(VEC[i].e_be));
            chk(mem_we == VEC[i].st, "R10 write flag", 32'(mem_we), 32'(VEC[i].st));
            if (VEC[i].st)
               chk(mem_wdata == VEC[i].e_out, "R3 R4 R5 store data", mem_wdata, VEC[i].e_out);
         end
         @(negedge clk);
         req_valid = 1'b0;
         #2;
         if (!VEC[i].st && !VEC[i].e_mis) begin
            chk(ld_valid == 1'b1, "R9 ld_valid", 32'(ld_valid), 32'h1);
            chk(busy == 1'b1, "R9 busy", 32'(busy), 32'h1);
            chk(ld_data == VEC[i].e_out, "R6 R7 load data", ld_data, VEC[i].e_out);
         end else begin
            chk(ld_valid == 1'b0, "R10 no response", 32'(ld_valid), 32'h0);
            chk(busy == 1'b0, "R10 not busy", 32'(busy), 32'h0);
         end
         @(negedge clk);
      end

      // R9 held request is blocked while busy
      @(negedge clk);
      req_valid = 1'b1; req_store = 1'b0;
      insn = mk_insn(1'b0, 3'b010, 12'h004); base = 32'h0000_9000;
      mem_rdata = 32'h0BAD_F00D;
      @(negedge clk);
      #2;
      chk(busy == 1'b1, "R9 busy with held request", 32'(busy), 32'h1);
      chk(mem_req == 1'b0, "R9 mem_req blocked while busy", 32'(mem_req), 32'h0);
      chk(ld_data == 32'h0BAD_F00D, "R9 word load data", ld_data, 32'h0BAD_F00D);
      @(negedge clk);
      #2;
      chk(mem_req == 1'b1, "R9 mem_req returns after busy", 32'(mem_req), 32'h1);
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);

      // R12 stalled memory does not take the request
      mem_ready = 1'b0;
      req_valid = 1'b1; req_store = 1'b0;
      insn = mk_insn(1'b0, 3'b000, 12'h000); base = 32'h0000_A000;
      #2;
      chk(req_taken == 1'b0, "R12 not taken under stall", 32'(req_taken), 32'h0);
      @(negedge clk);
      #2;
      chk(ld_valid == 1'b0, "R12 no response under stall", 32'(ld_valid), 32'h0);
      chk(busy == 1'b0, "R12 not busy under stall", 32'(busy), 32'h0);
      req_valid = 1'b0;
      mem_ready = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule